// File: doc/BRIEF.md
# Repeat-Prefix Iteration Sequencer

This block controls how often a single string operation is repeated. A start strobe delivers a repeat kind, an initial count and an address-size select. The sequencer then runs a loop. Before each pass it tests whether the count is exhausted. It then tests for a pending interrupt. Only after both tests does it issue an iteration-start strobe to the external operation datapath and wait for that datapath to report completion together with its zero flag. Each completed pass lowers the live count by one.

The loop ends in one of two ways. It finishes with a done strobe when the decremented count reaches zero, or when the repeat kind's zero-flag test fails. It stops with a suspend strobe when an interrupt is pending at the start of a pass. In that case the live count keeps the value it had after the last completed pass, so the operation can be restarted from that point with the same count. With a 16-bit address size, only the low half of the count takes part in the zero test and the decrement. The upper half is carried through unchanged.

Top module: `strrep_seq`

## Requirements
- R1: After reset the live count reads zero, no strobe is asserted, and the sequencer accepts a start.
- R2: If the effective count latched at start is zero, no iteration strobe is issued and the done strobe appears exactly two cycles after the start edge. The effective count is the full 32-bit value when wide_i=1 and bits [15:0] when wide_i=0. This zero test takes priority over a pending interrupt.
- R3: Each pass begins one cycle after its check cycle with a one-cycle iter_go_o. On iter_done_i the count drops by one. In 16-bit mode only bits [15:0] are decremented and bits [31:16] keep their latched value. In 32-bit mode all bits are decremented.
- R4: When an iteration's decrement leaves the effective count at zero, done_o pulses in the cycle that follows the iter_done_i edge, whatever the zero flag is.
- R5: The kind_i encoding is 2'b00 repeat always, 2'b01 repeat while equal, 2'b10 repeat while not equal, and 2'b11 behaves as 2'b00. While-equal ends after a pass that reports zf_i=0. While-not-equal ends after a pass that reports zf_i=1. Repeat-always never ends on the zero flag.
- R6: If irq_pend_i is high in a check cycle and the effective count is nonzero, the sequencer skips the pass and pulses suspend_o in the next cycle. count_o holds the value left by the last completed pass, and the sequencer returns to idle.
- R7: A start strobe that arrives while the sequencer is busy is ignored. It changes neither the count nor the kind of the running operation.
- R8: done_o and suspend_o are single-cycle pulses. At most one of iter_go_o, done_o and suspend_o is high in any cycle, and after either end strobe the sequencer is idle.
- R9: An iter_done_i pulse outside the wait for iteration completion has no effect on the count or the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled only when idle |
| kind_i | input | 2 | Repeat kind (see R5) |
| count_i | input | CNT_W | Initial count |
| wide_i | input | 1 | 1 selects the full-width count, 0 the low 16 bits |
| irq_pend_i | input | 1 | Pending interrupt, tested in each check cycle |
| iter_done_i | input | 1 | Datapath reports the current pass complete |
| zf_i | input | 1 | Zero flag left by the completed pass, valid with iter_done_i |
| iter_go_o | output | 1 | One-cycle strobe starting a pass |
| count_o | output | CNT_W | Live count register |
| suspend_o | output | 1 | One-cycle strobe: stopped for an interrupt, resumable |
| done_o | output | 1 | One-cycle strobe: loop finished |

## Verification
The bench sweeps every repeat kind against both address sizes, with initial counts of zero, one, a few, and values whose upper half is nonzero. Each combination runs under zero-flag sequences that are steady or that flip on the first or third pass, and with or without an interrupt before the second pass. The counts tell apart count-driven and flag-driven termination. The 16-bit cases with a nonzero upper half show whether the zero test and the decrement are confined to the low half. Each run compares the position of every iteration strobe, the count seen at it, the cycle and kind of the end strobe, and the final count against a bench-side arithmetic model. Busy-time starts and stray completion pulses are injected into every run to expose any sensitivity to them.

// File: rtl/strrep_pkg.sv
package strrep_pkg;

  typedef enum logic [1:0] {
    RPT_ALWAYS   = 2'b00,
    RPT_WHILE_EQ = 2'b01,
    RPT_WHILE_NE = 2'b10,
    RPT_RSVD     = 2'b11
  } rpt_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_RUN   = 3'd2,
    ST_DONE  = 3'd3,
    ST_SUSP  = 3'd4
  } seq_state_e;

  // Decide whether the loop may continue after a pass, given its zero flag.
  function automatic logic rpt_continue(rpt_kind_e kind, logic zf);
    logic keep;
    unique case (kind)
      RPT_WHILE_EQ: keep = zf;
      RPT_WHILE_NE: keep = ~zf;
      default:      keep = 1'b1;
    endcase
    return keep;
  endfunction

endpackage

// File: rtl/strrep_rst_sync.sv
module strrep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/strrep_count.sv
module strrep_count #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             wide_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             last_o
);

  localparam int UPPER_W = CNT_W - NARROW_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] dec_val;
  logic             wide_q;
  logic             cnt_en;

  generate
    if (UPPER_W > 0) begin : g_split
      logic [NARROW_W-1:0] low_dec;
      assign low_dec = cnt_q[NARROW_W-1:0] - NARROW_W'(1);
      always_comb begin
        if (wide_q) dec_val = cnt_q - CNT_W'(1);
        else        dec_val = {cnt_q[CNT_W-1:NARROW_W], low_dec};
      end
      assign zero_o = wide_q ? (cnt_q == '0) : (cnt_q[NARROW_W-1:0] == '0);
      assign last_o = wide_q ? (cnt_q == CNT_W'(1))
                             : (cnt_q[NARROW_W-1:0] == NARROW_W'(1));

      // R3: upper half untouched by a narrow decrement
      p_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !wide_q) |=> (cnt_q[CNT_W-1:NARROW_W] == $past(cnt_q[CNT_W-1:NARROW_W])));
    end else begin : g_full
      assign dec_val = cnt_q - CNT_W'(1);
      assign zero_o  = (cnt_q == '0);
      assign last_o  = (cnt_q == CNT_W'(1));
    end
  endgenerate

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = value_i;
    else if (dec_i) cnt_d = dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wide_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q  <= cnt_d;
      if (load_i) wide_q <= wide_i;
    end
  end

  assign count_o = cnt_q;

  // R3: a wide decrement lowers the full count by one
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && wide_q) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
  import strrep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       irq_i,
  input  logic       iter_done_i,
  input  logic       zf_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_last_i,
  output logic       load_o,
  output logic       dec_o,
  output logic       go_o,
  output logic       suspend_o,
  output logic       done_o
);

  seq_state_e state_q, state_d;
  rpt_kind_e  kind_q;
  logic       go_q, go_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    go_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cnt_zero_i)  state_d = ST_DONE;
        else if (irq_i)  state_d = ST_SUSP;
        else begin
          state_d = ST_RUN;
          go_d    = 1'b1;
        end
      end
      ST_RUN: begin
        if (iter_done_i) begin
          dec_o = 1'b1;
          if (cnt_last_i || !rpt_continue(kind_q, zf_i)) state_d = ST_DONE;
          else                                           state_d = ST_CHECK;
        end
      end
      ST_DONE, ST_SUSP: state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RPT_ALWAYS;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      if (load_o) kind_q <= rpt_kind_e'(kind_i);
    end
  end

  assign go_o      = go_q;
  assign done_o    = (state_q == ST_DONE);
  assign suspend_o = (state_q == ST_SUSP);

  // R8: strobes never overlap
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_o, done_o, suspend_o}));

  // R8: end strobes last one cycle and leave the sequencer idle
  p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || suspend_o) |=> (!done_o && !suspend_o && state_q == ST_IDLE));

  // R2: an exhausted count in a check cycle finishes without a pass
  p_zero_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && cnt_zero_i) |=> (done_o && !go_o));

  // R6: a pending interrupt with count left suspends before the pass
  p_irq_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !cnt_zero_i && irq_i) |=> (suspend_o && !go_o));

  // R4: the final decrement ends the loop
  p_last_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && iter_done_i && cnt_last_i) |=> done_o);

endmodule

// File: rtl/strrep_seq.sv
module strrep_seq #(
  parameter int CNT_W       = 32,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wide_i,
  input  logic             irq_pend_i,
  input  logic             iter_done_i,
  input  logic             zf_i,
  output logic             iter_go_o,
  output logic [CNT_W-1:0] count_o,
  output logic             suspend_o,
  output logic             done_o
);

  logic rst_n_s;
  logic load;
  logic dec;
  logic cnt_zero;
  logic cnt_last;

  strrep_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  strrep_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .kind_i      (kind_i),
    .irq_i       (irq_pend_i),
    .iter_done_i (iter_done_i),
    .zf_i        (zf_i),
    .cnt_zero_i  (cnt_zero),
    .cnt_last_i  (cnt_last),
    .load_o      (load),
    .dec_o       (dec),
    .go_o        (iter_go_o),
    .suspend_o   (suspend_o),
    .done_o      (done_o)
  );

  strrep_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_i  (load),
    .value_i (count_i),
    .wide_i  (wide_i),
    .dec_i   (dec),
    .count_o (count_o),
    .zero_o  (cnt_zero),
    .last_o  (cnt_last)
  );

  // R7 / R9: without a load or an accepted completion the count is frozen
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load && !dec) |=> $stable(count_o));

endmodule

// File: tb/test_strrep_seq.sv
module test_strrep_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, wide_i, irq_pend_i, iter_done_i, zf_i;
  logic [1:0]  kind_i;
  logic [31:0] count_i;
  logic        iter_go_o, suspend_o, done_o;
  logic [31:0] count_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strrep_seq i_strrep_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .count_i(count_i), .wide_i(wide_i), .irq_pend_i(irq_pend_i),
    .iter_done_i(iter_done_i), .zf_i(zf_i), .iter_go_o(iter_go_o),
    .count_o(count_o), .suspend_o(suspend_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit eff_zero(input logic [31:0] v, input logic w);
    return w ? (v == 32'd0) : (v[15:0] == 16'd0);
  endfunction

  function automatic logic [31:0] dec_cnt(input logic [31:0] v, input logic w);
    return w ? v - 32'd1 : {v[31:16], v[15:0] - 16'd1};
  endfunction

  function automatic bit keep_going(input logic [1:0] k, input logic zf);
    if (k == 2'b01) return zf;
    if (k == 2'b10) return !zf;
    return 1'b1;
  endfunction

  function automatic logic zf_at(input int i, input int flip_at, input logic base);
    return (i == flip_at) ? !base : base;
  endfunction

  task automatic run_op(input logic [1:0] kind, input logic [31:0] cnt, input logic wide,
                        input int flip_at, input logic zf_base, input int irq_at);
    logic [31:0] cur, live;
    int n, reason, k, gos, end_k;
    bit ended, was_done, was_susp;
    string rtag;
    cur = cnt; n = 0; reason = -1;
    if (eff_zero(cur, wide)) reason = 0;
    while (reason < 0 && n <= 40) begin
      if (n == irq_at) reason = 3;
      else begin
        logic z;
        z = zf_at(n, flip_at, zf_base);
        cur = dec_cnt(cur, wide);
        n++;
        if (eff_zero(cur, wide))    reason = 1;
        else if (!keep_going(kind, z)) reason = 2;
      end
    end
    if (reason < 0) return;
    case (reason)
      0: begin rtag = "R2"; end_k = 2; end
      1: begin rtag = "R4"; end_k = 2*n + 1; end
      2: begin rtag = "R5"; end_k = 2*n + 1; end
      default: begin rtag = "R6"; end_k = 2*n + 2; end
    endcase

    @(negedge clk);
    start_i = 1'b1; kind_i = kind; count_i = cnt; wide_i = wide;
    irq_pend_i = (irq_at == 0);
    @(negedge clk);
    k = 1; gos = 0; live = cnt; ended = 1'b0; was_done = 1'b0; was_susp = 1'b0;
    while (!ended && k < 200) begin
      start_i = 1'b0; iter_done_i = 1'b0;
      if (iter_go_o) begin
        chk(k == 2*gos + 2, "R3 go position", k, 2*gos + 2);
        chk(count_o == live, "R3 count at go", count_o, live);
        if (gos == 0) begin
          // R7: busy start with different fields
          start_i = 1'b1; count_i = ~cnt; kind_i = ~kind; wide_i = ~wide;
        end
        iter_done_i = 1'b1;
        zf_i = zf_at(gos, flip_at, zf_base);
        live = dec_cnt(live, wide);
        gos++;
        irq_pend_i = (gos == irq_at);
      end else if (done_o || suspend_o) begin
        ended = 1'b1; was_done = done_o; was_susp = suspend_o;
      end else if (k == 1) begin
        // R9: stray completion during a check cycle
        iter_done_i = 1'b1; zf_i = 1'b0;
      end
      if (!ended) begin
        @(negedge clk);
        k++;
      end
    end
    irq_pend_i = 1'b0; start_i = 1'b0; iter_done_i = 1'b0;
    chk(ended, {rtag, " end reached"}, 32'(k), 32'(end_k));
    chk(k == end_k, {rtag, " end cycle (R7 R9 stimulus applied)"}, 32'(k), 32'(end_k));
    chk(was_susp == (reason == 3), {rtag, " suspend vs done"}, {31'd0, was_susp}, {31'd0, reason == 3});
    chk(was_done == (reason != 3), {rtag, " done strobe"}, {31'd0, was_done}, {31'd0, reason != 3});
    chk(gos == n, {rtag, " iteration count"}, 32'(gos), 32'(n));
    chk(count_o == cur, {rtag, " final count R3"}, count_o, cur);
    @(negedge clk);
    chk(!done_o && !suspend_o && !iter_go_o, "R8 single-cycle end strobe", {29'd0, iter_go_o, done_o, suspend_o}, 32'd0);
    chk(count_o == cur, "R8 count held after end", count_o, cur);
  endtask

  function automatic logic [31:0] pick_cnt(input int i);
    case (i)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd3;
      3: return 32'd6;
      default: return 32'hABCD_0004;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 1'b0; kind_i = 2'b00; count_i = 32'd0; wide_i = 1'b0;
    irq_pend_i = 1'b0; iter_done_i = 1'b0; zf_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(count_o == 32'd0, "R1 reset count", count_o, 32'd0);
    chk(!iter_go_o && !done_o && !suspend_o, "R1 reset strobes", {29'd0, iter_go_o, done_o, suspend_o}, 32'd0);
    // R9: stray completion while idle
    iter_done_i = 1'b1;
    @(negedge clk);
    iter_done_i = 1'b0;
    @(negedge clk);
    chk(count_o == 32'd0, "R9 idle completion ignored", count_o, 32'd0);
    chk(!iter_go_o && !done_o && !suspend_o, "R9 idle no strobe", {29'd0, iter_go_o, done_o, suspend_o}, 32'd0);

    for (int kd = 0; kd < 4; kd++)
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 5; ci++)
          for (int fl = 0; fl < 3; fl++)
            for (int zb = 0; zb < 2; zb++)
              for (int iq = 0; iq < 2; iq++)
                run_op(2'(kd), pick_cnt(ci), w[0], (fl == 0) ? 0 : (fl == 1) ? 2 : 99,
                       zb[0], (iq == 0) ? 99 : 1);

    // R2: narrow mode ignores upper half when testing for zero
    run_op(2'b00, 32'h0005_0000, 1'b0, 99, 1'b0, 99);
    // R3: narrow decrement to zero keeps the upper half
    run_op(2'b00, 32'h1234_0001, 1'b0, 99, 1'b0, 99);
    // R3: wide decrement borrows across the halves, stopped by interrupt (R6)
    run_op(2'b00, 32'h0001_0000, 1'b1, 99, 1'b0, 2);
    // R5: while-equal stops on a clear flag in the first pass, wide borrow
    run_op(2'b01, 32'h0001_0000, 1'b1, 99, 1'b0, 99);
    // R5: while-not-equal stops on a set flag
    run_op(2'b10, 32'hFFFF_0009, 1'b0, 4, 1'b0, 99);
    // R2: zero count wins over a pending interrupt
    run_op(2'b01, 32'h0000_0000, 1'b1, 99, 1'b1, 0);
    // R6: interrupt before the first pass
    run_op(2'b11, 32'h0000_0005, 1'b0, 99, 1'b0, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule